// File: doc/BRIEF.md
# Hart Debug Halt and Step Controller

This block is the per-hart state machine that moves a processor core between normal execution and a debug-halted state. A halt can be entered for one of three reasons: a debugger halt request, a hardware trigger match, or the completion of one instruction in single-step mode. On every halt entry it records the reason in the debug control register and saves, in the debug PC register, the address at which execution should restart. It keeps the fetch stage stalled while halted and reports its halted status.

A debugger reads and writes the two debug registers through a small register-access port. This access works only while the hart is halted. A resume request clears the halt, sends the saved PC to the fetch stage as a redirect, and returns a one-cycle acknowledge. If the step bit is set, the hart runs exactly one more instruction and then halts again. When a halt is entered while the core is sleeping on a wait-for-interrupt, the block also raises a wake pulse so that the sleep ends.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: After reset the block is running: `halted_o`, `stall_o`, `resume_ack_o`, `redirect_valid_o` and `wfi_wake_o` are all low.
- R2: A `halt_req_i` seen while running halts the hart on the next cycle. The cause recorded is 3, and the debug PC is set to the retired PC + 4 of the most recent retirement, or to `RESET_PC` if nothing has retired yet. A retirement in the same cycle as the request counts as the most recent one.
- R3: A `trig_hit_i` seen while running halts the hart. The cause recorded is 2 and the debug PC is set to `trig_pc_i`. When a trigger and a halt request arrive in the same cycle, the trigger wins.
- R4: After a resume with the step bit set, the first `retire_i` halts the hart. The cause recorded is 4 and the debug PC is set to the retired PC + 4.
- R5: While halted, `stall_o` stays high and the hart remains halted for any length of time. A `retire_i` pulse has no effect on the debug PC.
- R6: A `resume_req_i` while halted with `halt_req_i` low does three things on the next cycle: it drops `halted_o`, pulses `resume_ack_o` for one cycle, and pulses `redirect_valid_o` with `redirect_pc_o` equal to the debug PC. A resume request while `halt_req_i` is high is ignored.
- R7: A halt entry while `wfi_i` is high pulses `wfi_wake_o` for one cycle. A halt entry with `wfi_i` low does not pulse it.
- R8: The debug control register is at address 0x7B0 and reads as follows: bits 31:28 hold 4, bits 8:6 hold the cause, bit 2 holds the step flag, bits 1:0 hold 3, and all other bits are 0. Only bit 2 can be written. The debug PC is at address 0x7B1, and on a write its bits 1:0 are forced to 0.
- R9: Each access on the register port gets `csr_ack_o` on the following cycle. The access returns `csr_err_o`, with no effect and zero read data, if the hart is not halted or the address is neither 0x7B0 nor 0x7B1.
- R10: After a resume with the step bit clear, retirements do not halt the hart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_req_i | input | 1 | Debugger halt request (level) |
| resume_req_i | input | 1 | Debugger resume request (pulse) |
| trig_hit_i | input | 1 | Trigger match pulse |
| trig_pc_i | input | XLEN | Address of the instruction that matched |
| retire_i | input | 1 | One instruction retired this cycle |
| retire_pc_i | input | XLEN | PC of the retired instruction |
| wfi_i | input | 1 | Core is sleeping on wait-for-interrupt |
| csr_req_i | input | 1 | Register access request |
| csr_we_i | input | 1 | Access is a write |
| csr_addr_i | input | AW | Register address |
| csr_wdata_i | input | XLEN | Write data |
| csr_ack_o | output | 1 | Access response valid |
| csr_err_o | output | 1 | Access refused |
| csr_rdata_o | output | XLEN | Read data |
| halted_o | output | 1 | Hart is debug-halted |
| stall_o | output | 1 | Stall instruction fetch |
| resume_ack_o | output | 1 | Resume served (pulse) |
| redirect_valid_o | output | 1 | Fetch redirect valid (pulse) |
| redirect_pc_o | output | XLEN | Fetch restart address |
| wfi_wake_o | output | 1 | End wait-for-interrupt (pulse) |

## Verification
The assertions check the following on every cycle: the one-cycle shape of the resume acknowledge and that it coincides with leaving the halt, that a wake pulse only comes with a halt entry, that a retirement during a step always halts, that the debug PC does not move while halted except through a register write, and that the register port answers one cycle after each request. Other behaviour can only be shown by the bench scenarios. These scenarios cover the actual cause codes and saved PCs for each halt reason, the PC advancing by 4 over a chain of steps, the trigger winning over a halt request in the same cycle, field masking and PC alignment on register writes, refused accesses, and free running once the step bit is cleared.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam logic [11:0] CSR_DCSR = 12'h7B0;
  localparam logic [11:0] CSR_DPC  = 12'h7B1;

  localparam logic [2:0] CAUSE_NONE  = 3'd0;
  localparam logic [2:0] CAUSE_TRIG  = 3'd2;
  localparam logic [2:0] CAUSE_HALT  = 3'd3;
  localparam logic [2:0] CAUSE_STEP  = 3'd4;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_STEP = 2'd2
  } hart_state_e;
endpackage

// File: rtl/dbg_fsm.sv
module dbg_fsm
  import dbg_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          ILEN_BYTES = 4,
  parameter logic [31:0] RESET_PC   = 32'h0000_0080
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            halt_req_i,
  input  logic            resume_req_i,
  input  logic            trig_hit_i,
  input  logic [XLEN-1:0] trig_pc_i,
  input  logic            retire_i,
  input  logic [XLEN-1:0] retire_pc_i,
  input  logic            wfi_i,
  input  logic            step_i,
  input  logic [XLEN-1:0] dpc_i,
  output logic            enter_o,
  output logic [2:0]      enter_cause_o,
  output logic [XLEN-1:0] enter_pc_o,
  output logic            halted_o,
  output logic            stall_o,
  output logic            resume_ack_o,
  output logic            redirect_valid_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic            wfi_wake_o
);
  localparam logic [XLEN-1:0] ILEN = XLEN'(ILEN_BYTES);

  hart_state_e     state_q;
  logic [XLEN-1:0] next_pc_q;
  logic [XLEN-1:0] seq_pc;
  logic            running;
  logic            do_resume;
  logic            ack_q, redir_q, wake_q;
  logic [XLEN-1:0] redir_pc_q;

  always_comb begin
    running   = (state_q != ST_HALT);
    seq_pc    = retire_i ? (retire_pc_i + ILEN) : next_pc_q;
    enter_o   = running && (trig_hit_i || halt_req_i ||
                            (state_q == ST_STEP && retire_i));
    if (trig_hit_i) begin
      enter_cause_o = CAUSE_TRIG;
      enter_pc_o    = trig_pc_i;
    end else if (halt_req_i) begin
      enter_cause_o = CAUSE_HALT;
      enter_pc_o    = seq_pc;
    end else begin
      enter_cause_o = CAUSE_STEP;
      enter_pc_o    = seq_pc;
    end
    do_resume = (state_q == ST_HALT) && resume_req_i && !halt_req_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_RUN;
      next_pc_q  <= XLEN'(RESET_PC);
      ack_q      <= 1'b0;
      redir_q    <= 1'b0;
      redir_pc_q <= '0;
      wake_q     <= 1'b0;
    end else begin
      ack_q   <= do_resume;
      redir_q <= do_resume;
      wake_q  <= enter_o && wfi_i;
      if (do_resume) redir_pc_q <= dpc_i;
      if (enter_o) begin
        state_q <= ST_HALT;
      end else if (do_resume) begin
        state_q <= step_i ? ST_STEP : ST_RUN;
      end
      if (do_resume) begin
        next_pc_q <= dpc_i;
      end else if (running && retire_i) begin
        next_pc_q <= retire_pc_i + ILEN;
      end
    end
  end

  assign halted_o         = (state_q == ST_HALT);
  assign stall_o          = (state_q == ST_HALT);
  assign resume_ack_o     = ack_q;
  assign redirect_valid_o = redir_q;
  assign redirect_pc_o    = redir_pc_q;
  assign wfi_wake_o       = wake_q;

  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    resume_ack_o |=> !resume_ack_o); // R6
  AST_ACK_LEAVES_HALT: assert property (@(posedge clk) disable iff (rst)
    resume_ack_o |-> (!halted_o && $past(halted_o))); // R6
  AST_WAKE_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
    wfi_wake_o |-> (halted_o && !$past(halted_o))); // R7
  AST_STEP_HALTS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STEP && retire_i) |=> halted_o); // R4
endmodule

// File: rtl/dbg_csr.sv
module dbg_csr
  import dbg_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int AW   = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            halted_i,
  input  logic            enter_i,
  input  logic [2:0]      enter_cause_i,
  input  logic [XLEN-1:0] enter_pc_i,
  input  logic            csr_req_i,
  input  logic            csr_we_i,
  input  logic [AW-1:0]   csr_addr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic            csr_ack_o,
  output logic            csr_err_o,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            step_o,
  output logic [XLEN-1:0] dpc_o
);
  localparam logic [XLEN-1:0] ALIGN_MASK = XLEN'(3);
  localparam logic [3:0]      DBG_VER    = 4'd4;

  logic [2:0]      cause_q;
  logic            step_q;
  logic [XLEN-1:0] dpc_q;
  logic            ack_q, err_q;
  logic [XLEN-1:0] rdata_q;
  logic            hit_dcsr, hit_dpc, access_ok;
  logic [XLEN-1:0] dcsr_val;

  always_comb begin
    hit_dcsr  = (csr_addr_i == AW'(CSR_DCSR));
    hit_dpc   = (csr_addr_i == AW'(CSR_DPC));
    access_ok = csr_req_i && halted_i && (hit_dcsr || hit_dpc);
    dcsr_val          = '0;
    dcsr_val[31:28]   = DBG_VER;
    dcsr_val[8:6]     = cause_q;
    dcsr_val[2]       = step_q;
    dcsr_val[1:0]     = 2'b11;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= CAUSE_NONE;
      step_q  <= 1'b0;
      dpc_q   <= '0;
      ack_q   <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q   <= csr_req_i;
      err_q   <= csr_req_i && !access_ok;
      rdata_q <= access_ok ? (hit_dcsr ? dcsr_val : dpc_q) : '0;
      if (enter_i) begin
        cause_q <= enter_cause_i;
        dpc_q   <= enter_pc_i;
      end else if (access_ok && csr_we_i) begin
        if (hit_dcsr) step_q <= csr_wdata_i[2];
        if (hit_dpc)  dpc_q  <= csr_wdata_i & ~ALIGN_MASK;
      end
    end
  end

  assign csr_ack_o   = ack_q;
  assign csr_err_o   = err_q;
  assign csr_rdata_o = rdata_q;
  assign step_o      = step_q;
  assign dpc_o       = dpc_q;

  AST_CSR_RESPONDS: assert property (@(posedge clk) disable iff (rst)
    csr_req_i |=> csr_ack_o); // R9
  AST_DPC_HELD: assert property (@(posedge clk) disable iff (rst)
    (halted_i && !(csr_req_i && csr_we_i)) |=> $stable(dpc_q)); // R5
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          AW         = 12,
  parameter int          ILEN_BYTES = 4,
  parameter logic [31:0] RESET_PC   = 32'h0000_0080
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            halt_req_i,
  input  logic            resume_req_i,
  input  logic            trig_hit_i,
  input  logic [XLEN-1:0] trig_pc_i,
  input  logic            retire_i,
  input  logic [XLEN-1:0] retire_pc_i,
  input  logic            wfi_i,
  input  logic            csr_req_i,
  input  logic            csr_we_i,
  input  logic [AW-1:0]   csr_addr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic            csr_ack_o,
  output logic            csr_err_o,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            halted_o,
  output logic            stall_o,
  output logic            resume_ack_o,
  output logic            redirect_valid_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic            wfi_wake_o
);
  logic            enter;
  logic [2:0]      enter_cause;
  logic [XLEN-1:0] enter_pc;
  logic            step;
  logic [XLEN-1:0] dpc;

  dbg_fsm #(
    .XLEN(XLEN), .ILEN_BYTES(ILEN_BYTES), .RESET_PC(RESET_PC)
  ) u_fsm (
    .clk, .rst, .halt_req_i, .resume_req_i, .trig_hit_i, .trig_pc_i,
    .retire_i, .retire_pc_i, .wfi_i,
    .step_i(step), .dpc_i(dpc),
    .enter_o(enter), .enter_cause_o(enter_cause), .enter_pc_o(enter_pc),
    .halted_o, .stall_o, .resume_ack_o, .redirect_valid_o, .redirect_pc_o,
    .wfi_wake_o
  );

  dbg_csr #(.XLEN(XLEN), .AW(AW)) u_csr (
    .clk, .rst, .halted_i(halted_o),
    .enter_i(enter), .enter_cause_i(enter_cause), .enter_pc_i(enter_pc),
    .csr_req_i, .csr_we_i, .csr_addr_i, .csr_wdata_i,
    .csr_ack_o, .csr_err_o, .csr_rdata_o,
    .step_o(step), .dpc_o(dpc)
  );
endmodule

// File: tb/tb_dbg_halt_ctrl.sv
module tb_dbg_halt_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic halt_req = 0, resume_req = 0, trig_hit = 0, retire = 0, wfi = 0;
  logic [31:0] trig_pc = 0, retire_pc = 0, wdata = 0;
  logic csr_req = 0, csr_we = 0;
  logic [11:0] addr = 0;
  logic csr_ack, csr_err, halted, stall, rack, rvalid, wake;
  logic [31:0] rdata, rpc;

  int n_chk = 0, n_bad = 0;
  logic [31:0] prev_dpc, rd;

  always #4 clk = ~clk;

  dbg_halt_ctrl dut (
    .clk, .rst, .halt_req_i(halt_req), .resume_req_i(resume_req),
    .trig_hit_i(trig_hit), .trig_pc_i(trig_pc), .retire_i(retire),
    .retire_pc_i(retire_pc), .wfi_i(wfi), .csr_req_i(csr_req),
    .csr_we_i(csr_we), .csr_addr_i(addr), .csr_wdata_i(wdata),
    .csr_ack_o(csr_ack), .csr_err_o(csr_err), .csr_rdata_o(rdata),
    .halted_o(halted), .stall_o(stall), .resume_ack_o(rack),
    .redirect_valid_o(rvalid), .redirect_pc_o(rpc), .wfi_wake_o(wake)
  );

  // kinds: 0 step-retire, 1 trigger, 2 halt request after a retire
  localparam int NV = 6;
  localparam logic [1:0]  V_KIND [NV] = '{2'd0, 2'd0, 2'd0, 2'd1, 2'd2, 2'd0};
  localparam logic [31:0] V_PC   [NV] = '{32'h100, 32'h104, 32'h108, 32'h200, 32'h300, 32'h2000};
  localparam logic [2:0]  V_CAUSE[NV] = '{3'd4, 3'd4, 3'd4, 3'd2, 3'd3, 3'd4};
  localparam logic [31:0] V_DPC  [NV] = '{32'h104, 32'h108, 32'h10C, 32'h200, 32'h304, 32'h2004};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic csr(input logic we, input logic [11:0] a, input logic [31:0] d);
    csr_req = 1; csr_we = we; addr = a; wdata = d;
    tick;
    csr_req = 0; csr_we = 0;
    rd = rdata;
  endtask

  task automatic do_resume(input logic [31:0] exp_pc);
    resume_req = 1; tick; resume_req = 0;
    chk("R6 ack", {31'b0, rack}, 32'd1);
    chk("R6 redirect", rvalid ? rpc : 32'hFFFF_FFFF, exp_pc);
    chk("R6 running", {31'b0, halted}, 32'd0);
    tick;
    chk("R6 ack pulse", {31'b0, rack}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); tick; tick;
    rst = 0;
    tick;
    // R1 reset state
    chk("R1 outputs", {27'b0, halted, stall, rack, rvalid, wake}, 32'd0);

    // R2 first halt with nothing retired, while in WFI (R7)
    wfi = 1; halt_req = 1; tick; halt_req = 0; wfi = 0;
    chk("R2 halted", {31'b0, halted}, 32'd1);
    chk("R7 wake", {31'b0, wake}, 32'd1);
    tick;
    chk("R7 wake pulse", {31'b0, wake}, 32'd0);
    csr(0, 12'h7B1, 0); chk("R2 dpc reset pc", rd, 32'h80);
    csr(0, 12'h7B0, 0); chk("R8 dcsr cause 3", rd, 32'h4000_00C3);
    prev_dpc = 32'h80;

    for (int i = 0; i < NV; i++) begin
      csr(1, 12'h7B0, (V_KIND[i] == 2'd0) ? 32'h4 : 32'h0);
      do_resume(prev_dpc);
      case (V_KIND[i])
        2'd0: begin retire_pc = V_PC[i]; retire = 1; tick; retire = 0; end
        2'd1: begin trig_pc = V_PC[i]; trig_hit = 1; tick; trig_hit = 0; end
        default: begin
          retire_pc = V_PC[i]; retire = 1; tick; retire = 0;
          halt_req = 1; tick; halt_req = 0;
        end
      endcase
      chk("R2/R3/R4 halted", {31'b0, halted}, 32'd1);
      chk("R7 no wake", {31'b0, wake}, 32'd0);
      csr(0, 12'h7B0, 0);
      chk("R2/R3/R4 cause", {29'b0, rd[8:6]}, {29'b0, V_CAUSE[i]});
      csr(0, 12'h7B1, 0);
      chk("R2/R3/R4 dpc", rd, V_DPC[i]);
      prev_dpc = V_DPC[i];
    end

    // R8 field masking and alignment
    csr(1, 12'h7B0, 32'hFFFF_FFFF);
    csr(0, 12'h7B0, 0); chk("R8 dcsr mask", rd, 32'h4000_0107);
    csr(1, 12'h7B0, 32'h0);
    csr(0, 12'h7B0, 0); chk("R8 step clear", rd, 32'h4000_0103);
    csr(1, 12'h7B1, 32'h403);
    csr(0, 12'h7B1, 0); chk("R8 dpc align", rd, 32'h400);

    // R5 halted holds, retire ignored
    retire_pc = 32'h900; retire = 1; tick; retire = 0;
    for (int k = 0; k < 1000; k++) begin
      if (!halted || !stall) begin
        chk("R5 stays halted", {30'b0, halted, stall}, 32'd3);
        break;
      end
      tick;
    end
    chk("R5 halted after wait", {30'b0, halted, stall}, 32'd3);
    csr(0, 12'h7B1, 0); chk("R5 dpc kept", rd, 32'h400);

    // R9 unknown address
    csr(0, 12'h7A0, 0);
    chk("R9 bad addr", {29'b0, csr_ack, csr_err, |rd}, 32'd6);

    // R6 resume ignored while halt request held
    halt_req = 1; resume_req = 1; tick; resume_req = 0;
    chk("R6 ignored", {30'b0, halted, rack}, 32'd2);
    halt_req = 0; tick;

    // R10 free run with step clear
    do_resume(32'h400);
    for (int k = 0; k < 5; k++) begin
      retire_pc = 32'h400 + 4 * k; retire = 1; tick; retire = 0;
      chk("R10 running", {31'b0, halted}, 32'd0);
    end
    csr(1, 12'h7B1, 32'h1234);
    chk("R9 refused running", {30'b0, csr_ack, csr_err}, 32'd3);

    // R3 trigger wins over halt request
    trig_pc = 32'h778; trig_hit = 1; halt_req = 1; tick;
    trig_hit = 0; halt_req = 0;
    csr(0, 12'h7B0, 0); chk("R3 priority cause", {29'b0, rd[8:6]}, 32'd2);
    csr(0, 12'h7B1, 0); chk("R3 trigger dpc", rd, 32'h778);

    // R2 retire and halt request together
    do_resume(32'h778);
    retire_pc = 32'h500; retire = 1; halt_req = 1; tick;
    retire = 0; halt_req = 0;
    chk("R7 no wake", {31'b0, wake}, 32'd0);
    csr(0, 12'h7B1, 0); chk("R2 same-cycle retire", rd, 32'h504);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule